// File: doc/BRIEF.md
# Timer Input-Capture and Event Status Unit

This block sits beside a timer's counter and turns external input transitions into time stamps. Up to four capture channels each watch one timer input. When a channel is routed to its input, switched on, and sees the chosen transition, it copies the count value presented on `cnt_val` into its own capture register and raises a capture flag. A single-cycle `upd_pulse` from the counter raises the update flag. A second capture on a channel whose flag is still set also raises that channel's overcapture flag.

Software reaches the block through a small register port. Writes are single-cycle strobes. Reads come from a combinational read multiplexer. Flags are cleared by writing a zero to the bit. A one in that bit leaves the flag as it is, so one flag can be cleared without disturbing the others. The interrupt output combines the update and capture flags with a matching enable register. The number of channels is a parameter. Bits that belong to absent channels cannot be written, which lets software find the channel count by writing ones and reading the result back.

Top module: `tim_capture_status`

## Requirements
- R1: Channel n captures only when its route field (address 0, bits [2n+1:2n]) holds 01 and its on bit (address 1, bit 4n) is 1. Any other route value, or an on bit of 0, leaves the channel's capture register and flag unchanged.
- R2: The transition that triggers a capture is set by the channel's edge bits in address 1: bit 4n+1 (P) and bit 4n+2 (N). P=0,N=0 selects rising. P=1,N=0 selects falling. P=1,N=1 selects both. P=0,N=1 selects rising. Transitions are judged against the input level at the previous clock edge.
- R3: On a capture, the capture register of channel n (read address 4+n) takes the `cnt_val` present at that clock edge, and flag bit n+1 at address 3 is set. Both are visible after that edge.
- R4: A cycle with `upd_pulse` high sets flag bit 0 after that edge.
- R5: A write to address 3 clears every flag bit written as 0 and leaves every flag bit written as 1 unchanged.
- R6: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R7: A capture on channel n while flag bit n+1 is already set sets overcapture bit 9+n at address 3. That bit is cleared only by writing 0 to it.
- R8: `irq` is high exactly when some bit among 0..4 is set both in the flags and in the enable register at address 2, which uses the same bit positions.
- R9: For channels at or above NUM_CH, the route field, the on/edge bits and the enable bit cannot be written and read 0. Their capture register reads 0, and their flag bits stay 0.
- R10: After reset, every register reads 0 and `irq` is low.
- R11: Writes to addresses 4..7 have no effect. Route fields and configuration bits read back as written, within the implemented channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Running count from the timer |
| upd_pulse | input | 1 | Counter overflow/underflow pulse |
| tin | input | 4 | Timer inputs, one per channel slot, already synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A stale previous-input register or a wrong edge decode shows up at the next clock edge. The result is a capture register that holds the wrong count, or a flag that is set when it should be clear. A flag-update fault shows up one edge after the offending write or event. Examples are a clear that wins over a set, or a write of one that erases a flag. The interrupt follows a wrong flag or enable bit in the same cycle, because it is combinational from those registers. A fault in overcapture detection shows only at the second capture on a channel whose flag is still set, so the stimulus holds flags uncleared across repeated edges.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int DW      = 16;
  localparam int MAX_CH  = 4;
  localparam int UPD_BIT = 0;
  localparam int CC_BASE = 1;
  localparam int OV_BASE = 9;

  localparam logic [1:0] ROUTE_PIN = 2'b01;

  localparam logic [2:0] A_ROUTE = 3'd0;
  localparam logic [2:0] A_CFG   = 3'd1;
  localparam logic [2:0] A_IEN   = 3'd2;
  localparam logic [2:0] A_FLAGS = 3'd3;

  // Transition detector: pol_n/pol_p select rising, falling or both
  function automatic logic edge_fire(input logic prev, input logic cur,
                                     input logic pol_p, input logic pol_n);
    logic rise, fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    case ({pol_n, pol_p})
      2'b01:   return fall;
      2'b11:   return rise | fall;
      default: return rise;
    endcase
  endfunction

  // Write-zero-to-clear: a written 1 keeps the bit
  function automatic logic [DW-1:0] wzc(input logic [DW-1:0] cur,
                                        input logic [DW-1:0] wdata,
                                        input logic we);
    return we ? (cur & wdata) : cur;
  endfunction

  function automatic logic [DW-1:0] route_mask(input int nch);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_CH; i++)
      if (i < nch) m[2*i +: 2] = 2'b11;
    return m;
  endfunction

  function automatic logic [DW-1:0] cfg_mask(input int nch);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_CH; i++)
      if (i < nch) m[4*i +: 3] = 3'b111;
    return m;
  endfunction

  function automatic logic [DW-1:0] ien_mask(input int nch);
    logic [DW-1:0] m;
    m = '0;
    m[UPD_BIT] = 1'b1;
    for (int i = 0; i < MAX_CH; i++)
      if (i < nch) m[CC_BASE + i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] flag_mask(input int nch);
    logic [DW-1:0] m;
    m = ien_mask(nch);
    for (int i = 0; i < MAX_CH; i++)
      if (i < nch) m[OV_BASE + i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/tcs_channel.sv
module tcs_channel
  import tcs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tin,
  input  logic [1:0]       route,
  input  logic             on,
  input  logic             pol_p,
  input  logic             pol_n,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             cap_evt,
  output logic [CNT_W-1:0] cap_val
);

  logic tin_q;
  logic edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tin_q <= 1'b0;
    else        tin_q <= tin;
  end

  assign edge_seen = edge_fire(tin_q, tin, pol_p, pol_n);
  assign cap_evt   = (route == ROUTE_PIN) && on && edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_val <= '0;
    else if (cap_evt) cap_val <= cnt_val;
  end

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val == $past(cnt_val)));  // R3
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val));  // R1

endmodule

// File: rtl/tcs_flags.sv
module tcs_flags
  import tcs_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_flags,
  input  logic              wr_ien,
  input  logic [DW-1:0]     wr_data,
  input  logic              upd_pulse,
  input  logic [NUM_CH-1:0] cap_evt,
  output logic [DW-1:0]     flags,
  output logic [DW-1:0]     ien,
  output logic              irq
);

  localparam logic [DW-1:0] F_MASK = flag_mask(NUM_CH);
  localparam logic [DW-1:0] E_MASK = ien_mask(NUM_CH);

  logic [DW-1:0]     flag_q, flag_d, set_v;
  logic [DW-1:0]     ien_q;
  logic [NUM_CH-1:0] ovr_evt;
  logic [4:0]        pend;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ovr
    assign ovr_evt[n] = cap_evt[n] & flag_q[CC_BASE + n];
  end

  always_comb begin
    set_v          = '0;
    set_v[UPD_BIT] = upd_pulse;
    for (int n = 0; n < NUM_CH; n++) begin
      set_v[CC_BASE + n] = cap_evt[n];
      set_v[OV_BASE + n] = ovr_evt[n];
    end
    flag_d = (wzc(flag_q, wr_data, wr_flags) | set_v) & F_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ien_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_ien) ien_q <= wr_data & E_MASK;
    end
  end

  assign pend  = flag_q[4:0] & ien_q[4:0];
  assign irq   = |pend;
  assign flags = flag_q;
  assign ien   = ien_q;

  AST_UPD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> flags[UPD_BIT]);  // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && wr_flags && !wr_data[UPD_BIT]) |=> flags[UPD_BIT]);  // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && !wr_data[UPD_BIT] && !upd_pulse) |=> !flags[UPD_BIT]);  // R5
  AST_KEEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[UPD_BIT] && !(wr_flags && !wr_data[UPD_BIT])) |=> flags[UPD_BIT]);  // R5
  AST_IRQ_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && ien[UPD_BIT] && !wr_ien) |=> irq);  // R8

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    AST_CC_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[n] |=> flags[CC_BASE + n]);  // R3
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt[n] && flags[CC_BASE + n]) |=> flags[OV_BASE + n]);  // R7
  end

endmodule

// File: rtl/tim_capture_status.sv
module tim_capture_status
  import tcs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             upd_pulse,
  input  logic [3:0]       tin,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [15:0]      wr_data,
  input  logic [2:0]       rd_addr,
  output logic [15:0]      rd_data,
  output logic             irq
);

  localparam logic [DW-1:0] R_MASK = route_mask(NUM_CH);
  localparam logic [DW-1:0] C_MASK = cfg_mask(NUM_CH);

  logic [DW-1:0]    route_q, cfg_q, flags, ien;
  logic [MAX_CH-1:0] cap_evt_all;
  logic [CNT_W-1:0] cap_arr [MAX_CH];
  logic             wr_route, wr_cfg, wr_ien, wr_flags;

  assign wr_route = wr_en && (wr_addr == A_ROUTE);
  assign wr_cfg   = wr_en && (wr_addr == A_CFG);
  assign wr_ien   = wr_en && (wr_addr == A_IEN);
  assign wr_flags = wr_en && (wr_addr == A_FLAGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      cfg_q   <= '0;
    end else begin
      if (wr_route) route_q <= wr_data & R_MASK;
      if (wr_cfg)   cfg_q   <= wr_data & C_MASK;
    end
  end

  for (genvar n = 0; n < MAX_CH; n++) begin : g_ch
    if (n < NUM_CH) begin : g_on
      tcs_channel #(.CNT_W(CNT_W)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .tin     (tin[n]),
        .route   (route_q[2*n +: 2]),
        .on      (cfg_q[4*n]),
        .pol_p   (cfg_q[4*n+1]),
        .pol_n   (cfg_q[4*n+2]),
        .cnt_val (cnt_val),
        .cap_evt (cap_evt_all[n]),
        .cap_val (cap_arr[n])
      );
    end else begin : g_off
      assign cap_evt_all[n] = 1'b0;
      assign cap_arr[n]     = '0;
    end
  end

  tcs_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_flags  (wr_flags),
    .wr_ien    (wr_ien),
    .wr_data   (wr_data),
    .upd_pulse (upd_pulse),
    .cap_evt   (cap_evt_all[NUM_CH-1:0]),
    .flags     (flags),
    .ien       (ien),
    .irq       (irq)
  );

  always_comb begin
    case (rd_addr)
      A_ROUTE: rd_data = route_q;
      A_CFG:   rd_data = cfg_q;
      A_IEN:   rd_data = ien;
      A_FLAGS: rd_data = flags;
      default: rd_data = DW'(cap_arr[rd_addr[1:0]]);
    endcase
  end

  AST_ROUTE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_route |=> (route_q == ($past(wr_data) & R_MASK)));  // R11
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(cfg_q));  // R11

endmodule

// File: tb/sim_tim_capture_status.sv
module sim_tim_capture_status;

  localparam int PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt_val;
  logic        upd_pulse;
  logic [3:0]  tin;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data, rd_data1;
  logic        irq, irq1;

  int n_chk  = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  tim_capture_status #(.NUM_CH(4), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .upd_pulse(upd_pulse),
    .tin(tin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  tim_capture_status #(.NUM_CH(2), .CNT_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .upd_pulse(upd_pulse),
    .tin(tin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data1), .irq(irq1));

  // ---------------- reference model of u0 (four channels) ----------------
  logic [15:0] m_route, m_cfg, m_ien, m_flags;
  logic [15:0] m_cap [4];
  logic [3:0]  m_prev;

  function automatic bit exp_hit(int ch, logic [15:0] rt, logic [15:0] cf,
                                 logic [3:0] prev, logic [3:0] cur);
    bit went_up, went_down;
    if (rt[2*ch +: 2] != 2'b01 || !cf[4*ch]) return 0;
    went_up   = !prev[ch] && cur[ch];
    went_down = prev[ch] && !cur[ch];
    if (cf[4*ch+1] && cf[4*ch+2]) return went_up || went_down;
    if (cf[4*ch+1]) return went_down;
    return went_up;
  endfunction

  function automatic bit exp_irq(logic [15:0] fl, logic [15:0] en);
    for (int b = 0; b < 5; b++)
      if (fl[b] && en[b]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [15:0] nf;
    if (!rst_n) begin
      m_route = 0; m_cfg = 0; m_ien = 0; m_flags = 0; m_prev = 0;
      for (int c = 0; c < 4; c++) m_cap[c] = 0;
    end else begin
      nf = m_flags;
      if (wr_en && wr_addr == 3'd3) nf = nf & wr_data;
      if (upd_pulse) nf[0] = 1'b1;
      for (int c = 0; c < 4; c++) begin
        if (exp_hit(c, m_route, m_cfg, m_prev, tin)) begin
          if (m_flags[1+c]) nf[9+c] = 1'b1;
          nf[1+c] = 1'b1;
          m_cap[c] = cnt_val;
        end
      end
      m_flags = nf & 16'h1E1F;
      if (wr_en && wr_addr == 3'd0) m_route = wr_data & 16'h00FF;
      if (wr_en && wr_addr == 3'd1) m_cfg   = wr_data & 16'h7777;
      if (wr_en && wr_addr == 3'd2) m_ien   = wr_data & 16'h001F;
      m_prev = tin;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int a);
    case (a)
      0, 1:    return "R11 config readback";
      2:       return "R8 enable readback";
      3:       return "R5 flag register";
      default: return "R3 capture register";
    endcase
  endfunction

  task automatic check_all();
    logic [15:0] e;
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      case (a)
        0: e = m_route;
        1: e = m_cfg;
        2: e = m_ien;
        3: e = m_flags;
        default: e = m_cap[a-4];
      endcase
      chk(rd_data, e, tag_of(a));
    end
    chk({15'd0, irq}, {15'd0, exp_irq(m_flags, m_ien)}, "R8 irq");
  endtask

  task automatic peek(input logic [2:0] a, input logic [15:0] e, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data, e, tag);
  endtask

  task automatic peek1(input logic [2:0] a, input logic [15:0] mask,
                       input logic [15:0] e, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data1 & mask, e, tag);
  endtask

  task automatic tick(input logic w, input logic [2:0] a, input logic [15:0] d,
                      input logic u, input logic [3:0] t, input logic [15:0] c);
    @(negedge clk);
    check_all();
    wr_en = w; wr_addr = a; wr_data = d; upd_pulse = u; tin = t; cnt_val = c;
    @(posedge clk);
    #1;
    wr_en = 1'b0; upd_pulse = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cnt_val = 0; upd_pulse = 0; tin = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R10: reset state
    for (int a = 0; a < 8; a++) peek(3'(a), 16'h0000, "R10 reset value");
    chk({15'd0, irq}, 16'h0000, "R10 irq after reset");

    // Routing all channels to their pins, then per-channel edge choice
    tick(1, 3'd0, 16'h0055, 0, 4'b0000, 16'h0000);
    peek(3'd0, 16'h0055, "R11 route readback");
    tick(1, 3'd1, 16'h5731, 0, 4'b0000, 16'h0000);
    peek(3'd1, 16'h5731, "R11 cfg readback");

    // All inputs rise: ch0 rising, ch1 falling, ch2 both, ch3 N-only (rising)
    tick(0, 3'd0, 16'h0000, 0, 4'b1111, 16'h0100);
    peek(3'd4, 16'h0100, "R3 ch0 captures count on rising edge");
    peek(3'd5, 16'h0000, "R2 falling-edge channel ignores rise");
    peek(3'd6, 16'h0100, "R2 both-edge channel captures rise");
    peek(3'd7, 16'h0100, "R2 N-only setting captures rise");
    peek(3'd3, 16'h001A, "R3 capture flags set");

    // All inputs fall: ch1 and ch2 capture; ch2 flag already set -> overcapture
    tick(0, 3'd0, 16'h0000, 0, 4'b0000, 16'h0200);
    peek(3'd4, 16'h0100, "R2 rising-edge channel ignores fall");
    peek(3'd5, 16'h0200, "R2 falling-edge channel captures fall");
    peek(3'd6, 16'h0200, "R2 both-edge channel captures fall");
    peek(3'd3, 16'h081E, "R7 overcapture on repeated capture");

    // Clear one flag by writing zero there, ones elsewhere
    tick(1, 3'd3, 16'hFFFD, 0, 4'b0000, 16'h0200);
    peek(3'd3, 16'h081C, "R5 write zero clears only that flag");

    // Clear all while update pulse and ch0 capture occur: sets win
    tick(1, 3'd3, 16'h0000, 1, 4'b0001, 16'h0300);
    peek(3'd3, 16'h0003, "R6 set beats simultaneous clear");
    peek(3'd4, 16'h0300, "R3 ch0 recapture");
    chk({15'd0, irq}, 16'h0000, "R8 irq low with enables clear");

    // Interrupt enable combinations
    tick(1, 3'd2, 16'h0010, 0, 4'b0001, 16'h0300);
    chk({15'd0, irq}, 16'h0000, "R8 irq low when enabled flag clear");
    tick(1, 3'd2, 16'h0002, 0, 4'b0001, 16'h0300);
    chk({15'd0, irq}, 16'h0001, "R8 irq high on enabled capture flag");
    tick(1, 3'd3, 16'hFFFD, 0, 4'b0001, 16'h0300);
    chk({15'd0, irq}, 16'h0000, "R8 irq low after flag cleared");
    peek(3'd3, 16'h0001, "R5 written ones keep update flag");

    // Route ch0 off: toggles must not capture
    tick(1, 3'd0, 16'h0054, 0, 4'b0001, 16'h0300);
    tick(0, 3'd0, 16'h0000, 0, 4'b0000, 16'h0400);
    tick(0, 3'd0, 16'h0000, 0, 4'b0001, 16'h0500);
    peek(3'd4, 16'h0300, "R1 routed-off channel holds capture");
    peek(3'd3, 16'h0001, "R1 routed-off channel leaves flag");

    // Writes to capture addresses are ignored
    tick(1, 3'd5, 16'hBEEF, 0, 4'b0001, 16'h0500);
    peek(3'd5, 16'h0200, "R11 capture address not writable");

    // Two-channel instance: absent channels read zero
    tick(1, 3'd1, 16'hFFFF, 0, 4'b0001, 16'h0600);
    peek1(3'd1, 16'hFFFF, 16'h0077, "R9 cfg bits of absent channels");
    tick(1, 3'd0, 16'hFFFF, 0, 4'b0001, 16'h0600);
    peek1(3'd0, 16'hFFFF, 16'h000F, "R9 route fields of absent channels");
    tick(1, 3'd2, 16'hFFFF, 0, 4'b0001, 16'h0600);
    peek1(3'd2, 16'hFFFF, 16'h0007, "R9 enable bits of absent channels");
    tick(0, 3'd0, 16'h0000, 0, 4'b1101, 16'h0700);
    peek1(3'd3, 16'h1818, 16'h0000, "R9 absent channels raise no flags");
    peek1(3'd6, 16'hFFFF, 16'h0000, "R9 absent capture register");
    peek1(3'd7, 16'hFFFF, 16'h0000, "R9 absent capture register");

    // Constrained random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [2:0]  a;
      logic [15:0] d;
      w = ($urandom % 100) < 20;
      a = 3'($urandom % 8);
      d = 16'($urandom);
      if (a == 3'd3) d = d | 16'($urandom) | 16'($urandom);
      tick(w, a, d, ($urandom % 100) < 10, tin ^ 4'($urandom % 16 & $urandom % 16),
           16'($urandom));
    end
    @(negedge clk);
    check_all();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule